// File: doc/BRIEF.md
# Memory Protection Configuration Register Bank

This block keeps the programmable state of a physical memory protection unit. That state has three parts. Each region has an 8-bit configuration byte and an address register. A small security flag register holds the machine-level lockdown, whitelist and lock-bypass controls.

Software reaches the bank through CSR-style ports:

- A packed configuration port. Each word carries one byte for each of several neighbouring regions.
- An address port. It selects a single region.
- A security flag port.

Every write passes through a set of filters. These are per-region locks, locking of the next top-of-range region, sticky security bits, and a table of encodings that are forbidden under lockdown. Only writes that pass the filters change state.

The whole configuration and address state goes out as flat vectors to the range decoder and access checker. The bank also drives the count of active rules and a one-cycle pulse. The checker or a translation cache can use the pulse to drop cached permissions.

Top module: `pmp_cfg_bank`

## Requirements
- R1: Configuration word n written through the packed port holds one byte per region, BPC = XLEN/8 bytes per word. Byte k (bits 8k+7:8k) belongs to region n*BPC+k. Reading word n returns the same packing.
- R2: The whole byte is stored. Bit 0 is read, bit 1 is write, bit 2 is execute, bit 7 is lock. Bits 4:3 are the match mode: 0 off, 1 top-of-range, 2 four-byte, 3 power-of-two.
- R3: A region is write-protected when its lock bit is set and the bypass flag is clear. While write-protected, configuration writes and address writes to that region are ignored. When bypass is set, those same writes take effect.
- R4: An address write to region k is ignored when region k+1 exists and is in top-of-range mode and is write-protected.
- R5: When the lockdown flag is set and bypass is clear, a configuration byte whose 4-bit code {lock,read,write,execute} is 9, 10, 11 or 13 is rejected. All other codes are accepted.
- R6: Writes to configuration words or address indices that lie past the implemented regions are ignored, and reads of them return zero.
- R7: The security flags are laid out as bit 0 lockdown, bit 1 whitelist and bit 2 bypass. Once set, lockdown and whitelist stay set until reset.
- R8: Bypass cannot go from 0 to 1 while any region has its lock bit set. It can always be cleared.
- R9: `rule_count` equals the number of regions whose match mode is not off.
- R10: `prot_changed` is high for exactly the one cycle after any of these: a configuration byte or address write that takes effect, or a write that sets a sticky flag that was clear. Writing a value equal to the stored one gives no pulse. A change of bypass alone gives no pulse.
- R11: Reset clears every configuration byte, address register and security flag, and the pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Packed configuration word write strobe |
| cfg_idx | input | CIW | Packed configuration word index |
| cfg_wdata | input | XLEN | Packed configuration write data |
| cfg_rdata | output | XLEN | Packed configuration word at `cfg_idx` |
| addr_we | input | 1 | Address register write strobe |
| addr_idx | input | AIW | Address register index |
| addr_wdata | input | XLEN | Address write data |
| addr_rdata | output | XLEN | Address register at `addr_idx` |
| sec_we | input | 1 | Security flag write strobe |
| sec_wdata | input | 3 | Security flag write data |
| sec_flags | output | 3 | Security flags {bypass, whitelist, lockdown} |
| cfg_flat | output | NREG*8 | All configuration bytes, region r at bits 8r+7:8r |
| addr_flat | output | NREG*XLEN | All address registers, region r at slice r |
| rule_count | output | CNTW | Number of regions with match mode not off |
| prot_changed | output | 1 | One-cycle pulse after an effective protection change |

## Verification
Configuration words are written with mixed modes in each byte lane. This separates the lane-to-region mapping from the rule count. Rewrites of identical words confirm that no pulse fires when nothing changes.

Lock behaviour is tried three ways:
- with bypass clear and set, which separates the plain lock filter from the bypass override;
- on the region just below a locked top-of-range entry, which isolates the neighbour guard;
- against a region whose upper neighbour is unlocked, which confirms the guard stays off there.

Under lockdown, a single word carries forbidden and permitted codes side by side. This shows that the code table filters each byte on its own. Sticky-flag clears and bypass requests made while a lock is held tell the sticky rule apart from the bypass rule.

// File: rtl/pmp_cfg_bank.sv
module pmp_cfg_bank #(
  parameter int NREG = 16,
  parameter int XLEN = 32,
  parameter int BPC  = XLEN / 8,
  parameter int CIW  = $clog2((NREG + BPC - 1) / BPC) + 1,
  parameter int AIW  = $clog2(NREG) + 1,
  parameter int CNTW = $clog2(NREG + 1)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 cfg_we,
  input  logic [CIW-1:0]       cfg_idx,
  input  logic [XLEN-1:0]      cfg_wdata,
  output logic [XLEN-1:0]      cfg_rdata,
  input  logic                 addr_we,
  input  logic [AIW-1:0]       addr_idx,
  input  logic [XLEN-1:0]      addr_wdata,
  output logic [XLEN-1:0]      addr_rdata,
  input  logic                 sec_we,
  input  logic [2:0]           sec_wdata,
  output logic [2:0]           sec_flags,
  output logic [NREG*8-1:0]    cfg_flat,
  output logic [NREG*XLEN-1:0] addr_flat,
  output logic [CNTW-1:0]      rule_count,
  output logic                 prot_changed
);

  logic [7:0]      cfg_q  [NREG];
  logic [XLEN-1:0] addr_q [NREG];
  logic            ldn_q, wl_q, byp_q, pulse_q;
  logic [NREG-1:0] ro, tor, locked, cfg_take, addr_take;
  logic            sticky_rise;

  function automatic logic forbidden(input logic [7:0] b);
    case ({b[7], b[0], b[1], b[2]})
      4'd9, 4'd10, 4'd11, 4'd13: forbidden = 1'b1;
      default:                   forbidden = 1'b0;
    endcase
  endfunction

  for (genvar r = 0; r < NREG; r++) begin : g_reg
    localparam int SLOT = r % BPC;
    localparam int WORD = r / BPC;
    logic [7:0] nb;
    logic       nxt_guard;

    assign locked[r] = cfg_q[r][7];
    assign ro[r]     = cfg_q[r][7] & ~byp_q;
    assign tor[r]    = (cfg_q[r][4:3] == 2'd1);
    assign nb        = cfg_wdata[SLOT*8 +: 8];

    if (r < NREG - 1) begin : g_nxt
      assign nxt_guard = tor[r+1] & ro[r+1];
    end else begin : g_last
      assign nxt_guard = 1'b0;
    end

    assign cfg_take[r] = cfg_we && (cfg_idx == CIW'(WORD)) && (nb != cfg_q[r]) &&
                         !ro[r] && !(ldn_q && !byp_q && forbidden(nb));
    assign addr_take[r] = addr_we && (addr_idx == AIW'(r)) && (addr_wdata != addr_q[r]) &&
                          !ro[r] && !nxt_guard;

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        cfg_q[r]  <= '0;
        addr_q[r] <= '0;
      end else begin
        if (cfg_take[r])  cfg_q[r]  <= nb;
        if (addr_take[r]) addr_q[r] <= addr_wdata;
      end
    end

    assign cfg_flat[r*8 +: 8]       = cfg_q[r];
    assign addr_flat[r*XLEN +: XLEN] = addr_q[r];
  end

  always_comb begin
    cfg_rdata  = '0;
    addr_rdata = '0;
    rule_count = '0;
    for (int r = 0; r < NREG; r++) begin
      if (cfg_idx == CIW'(r / BPC)) cfg_rdata[(r % BPC)*8 +: 8] = cfg_q[r];
      if (addr_idx == AIW'(r)) addr_rdata = addr_q[r];
      rule_count = rule_count + {{(CNTW-1){1'b0}}, cfg_q[r][4:3] != 2'd0};
    end
  end

  assign sticky_rise = sec_we & ((sec_wdata[0] & ~ldn_q) | (sec_wdata[1] & ~wl_q));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ldn_q   <= 1'b0;
      wl_q    <= 1'b0;
      byp_q   <= 1'b0;
      pulse_q <= 1'b0;
    end else begin
      if (sec_we) begin
        ldn_q <= ldn_q | sec_wdata[0];
        wl_q  <= wl_q  | sec_wdata[1];
        byp_q <= sec_wdata[2] & (byp_q | ~(|locked));
      end
      pulse_q <= (|cfg_take) | (|addr_take) | sticky_rise;
    end
  end

  assign sec_flags    = {byp_q, wl_q, ldn_q};
  assign prot_changed = pulse_q;

endmodule

// File: rtl/pmp_cfg_bank_chk.sv
module pmp_cfg_bank_chk #(
  parameter int NREG = 16,
  parameter int XLEN = 32
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic [NREG*8-1:0]    cfg_flat,
  input logic [NREG*XLEN-1:0] addr_flat,
  input logic [2:0]           sec_flags,
  input logic                 prot_changed
);

  logic [NREG-1:0] lk;

  function automatic logic bad_code(input logic [7:0] b);
    bad_code = (b[7] && !b[1] && !b[0] && b[2]) || (b[7] && b[1] && !b[0]) ||
               (b[7] && b[0] && !b[1] && b[2]);
  endfunction

  for (genvar r = 0; r < NREG; r++) begin : g_chk
    assign lk[r] = cfg_flat[r*8+7];

    p_locked_cfg_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_flat[r*8+7] && !sec_flags[2]) |=> $stable(cfg_flat[r*8 +: 8]));

    p_locked_addr_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_flat[r*8+7] && !sec_flags[2]) |=> $stable(addr_flat[r*XLEN +: XLEN]));

    p_lockdown_filter_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (sec_flags[0] && !sec_flags[2] && !bad_code(cfg_flat[r*8 +: 8]))
        |=> !bad_code(cfg_flat[r*8 +: 8]));

    if (r < NREG - 1) begin : g_tor
      p_tor_guard_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_flat[(r+1)*8+7] && cfg_flat[(r+1)*8+3] && !cfg_flat[(r+1)*8+4] && !sec_flags[2])
          |=> $stable(addr_flat[r*XLEN +: XLEN]));
    end
  end

  p_sticky_lockdown_r7: assert property (@(posedge clk) disable iff (!rst_n)
    sec_flags[0] |=> sec_flags[0]);

  p_sticky_whitelist_r7: assert property (@(posedge clk) disable iff (!rst_n)
    sec_flags[1] |=> sec_flags[1]);

  p_bypass_block_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!sec_flags[2] && (|lk)) |=> !sec_flags[2]);

  p_pulse_on_change_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (!$stable(cfg_flat) || !$stable(addr_flat)) |-> prot_changed);

endmodule

bind pmp_cfg_bank pmp_cfg_bank_chk #(.NREG(NREG), .XLEN(XLEN)) chk_i (
  .clk(clk), .rst_n(rst_n), .cfg_flat(cfg_flat), .addr_flat(addr_flat),
  .sec_flags(sec_flags), .prot_changed(prot_changed)
);

// File: tb/pmp_cfg_bank_tb_top.sv
module pmp_cfg_bank_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int NREG = 16;
  localparam int XLEN = 32;
  localparam int CIW  = 3;
  localparam int AIW  = 5;
  localparam int CNTW = 5;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cfg_we = 1'b0, addr_we = 1'b0, sec_we = 1'b0;
  logic [CIW-1:0] cfg_idx = '0;
  logic [AIW-1:0] addr_idx = '0;
  logic [XLEN-1:0] cfg_wdata = '0, addr_wdata = '0;
  logic [2:0] sec_wdata = '0;
  logic [XLEN-1:0] cfg_rdata, addr_rdata;
  logic [2:0] sec_flags;
  logic [NREG*8-1:0] cfg_flat;
  logic [NREG*XLEN-1:0] addr_flat;
  logic [CNTW-1:0] rule_count;
  logic prot_changed;

  int n_tests = 0;
  int n_fail = 0;
  bit done = 1'b0;

  typedef struct {
    int sel;
    int idx;
    logic [31:0] expv;
    string req;
  } item_t;
  item_t sb_q[$];
  event chk_ev, done_ev;

  always #(CLK_PERIOD/2) clk = ~clk;

  pmp_cfg_bank #(.NREG(NREG), .XLEN(XLEN)) dut_i (
    .clk(clk), .rst_n(rst_n),
    .cfg_we(cfg_we), .cfg_idx(cfg_idx), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
    .addr_we(addr_we), .addr_idx(addr_idx), .addr_wdata(addr_wdata), .addr_rdata(addr_rdata),
    .sec_we(sec_we), .sec_wdata(sec_wdata), .sec_flags(sec_flags),
    .cfg_flat(cfg_flat), .addr_flat(addr_flat), .rule_count(rule_count),
    .prot_changed(prot_changed)
  );

  function automatic logic [31:0] observe(int sel, int idx);
    case (sel)
      0: observe = {24'd0, cfg_flat[idx*8 +: 8]};
      1: observe = addr_flat[idx*XLEN +: XLEN];
      2: observe = {29'd0, sec_flags};
      3: observe = {27'd0, rule_count};
      4: observe = {31'd0, prot_changed};
      5: observe = cfg_rdata;
      default: observe = addr_rdata;
    endcase
  endfunction

  initial begin
    forever begin
      @(chk_ev);
      while (sb_q.size() > 0) begin
        item_t it;
        logic [31:0] act;
        it = sb_q.pop_front();
        act = observe(it.sel, it.idx);
        n_tests++;
        if (act !== it.expv) begin
          n_fail++;
          $display("FAIL %s sel=%0d idx=%0d actual=%h expected=%h", it.req, it.sel, it.idx, act, it.expv);
        end
      end
      ->done_ev;
    end
  end

  task automatic expect_item(int sel, int idx, logic [31:0] v, string req);
    item_t it;
    it.sel = sel; it.idx = idx; it.expv = v; it.req = req;
    sb_q.push_back(it);
  endtask

  task automatic check_now();
    ->chk_ev;
    @(done_ev);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic cfg_wr(int idx, logic [31:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_idx = CIW'(idx); cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic addr_wr(int idx, logic [31:0] d);
    @(negedge clk);
    addr_we = 1'b1; addr_idx = AIW'(idx); addr_wdata = d;
    @(negedge clk);
    addr_we = 1'b0;
  endtask

  task automatic sec_wr(logic [2:0] d);
    @(negedge clk);
    sec_we = 1'b1; sec_wdata = d;
    @(negedge clk);
    sec_we = 1'b0;
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: run did not complete");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    do_reset();
    // R11 reset state
    expect_item(0, 0, 0, "R11"); expect_item(0, 15, 0, "R11");
    expect_item(1, 0, 0, "R11"); expect_item(2, 0, 0, "R11");
    expect_item(3, 0, 0, "R11"); expect_item(4, 0, 0, "R11");
    check_now();

    // R1 R2 R9 R10 packing of mixed modes
    cfg_wr(0, 32'h1100180B);
    expect_item(0, 0, 32'h0B, "R1"); expect_item(0, 1, 32'h18, "R2");
    expect_item(0, 2, 32'h00, "R1"); expect_item(0, 3, 32'h11, "R1");
    expect_item(3, 0, 3, "R9"); expect_item(4, 0, 1, "R10");
    check_now();
    @(negedge clk);
    expect_item(4, 0, 0, "R10 one cycle"); check_now();

    cfg_wr(2, 32'h00000019);
    expect_item(0, 8, 32'h19, "R1"); expect_item(3, 0, 4, "R9");
    check_now();

    cfg_idx = 3'd0; #1;
    expect_item(5, 0, 32'h1100180B, "R1 read"); check_now();
    cfg_idx = 3'd4; #1;
    expect_item(5, 0, 0, "R6 read"); check_now();
    cfg_wr(5, 32'hFFFFFFFF);
    expect_item(4, 0, 0, "R6"); expect_item(0, 15, 0, "R6"); check_now();

    cfg_wr(0, 32'h1100180B);
    expect_item(4, 0, 0, "R10 equal value"); check_now();

    addr_wr(1, 32'h100);
    expect_item(1, 1, 32'h100, "R3"); expect_item(4, 0, 1, "R10"); check_now();
    addr_idx = 5'd1; #1;
    expect_item(6, 0, 32'h100, "R6 in-range read"); check_now();
    addr_wr(20, 32'h777);
    expect_item(4, 0, 0, "R6"); check_now();
    addr_idx = 5'd20; #1;
    expect_item(6, 0, 0, "R6 read"); check_now();

    // lock region 2 in top-of-range mode
    cfg_wr(0, 32'h1188180B);
    expect_item(0, 2, 32'h88, "R2"); expect_item(3, 0, 5, "R9"); check_now();
    cfg_wr(0, 32'h1100180B);
    expect_item(0, 2, 32'h88, "R3"); expect_item(4, 0, 0, "R3"); check_now();
    addr_wr(2, 32'h222);
    expect_item(1, 2, 0, "R3"); expect_item(4, 0, 0, "R3"); check_now();
    addr_wr(1, 32'h200);
    expect_item(1, 1, 32'h100, "R4"); expect_item(4, 0, 0, "R4"); check_now();
    addr_wr(3, 32'h300);
    expect_item(1, 3, 32'h300, "R4 unguarded"); check_now();
    addr_wr(0, 32'h40);
    expect_item(1, 0, 32'h40, "R4 non-tor neighbour"); check_now();

    sec_wr(3'b100);
    expect_item(2, 0, 0, "R8"); expect_item(4, 0, 0, "R10"); check_now();

    sec_wr(3'b001);
    expect_item(2, 0, 1, "R7"); expect_item(4, 0, 1, "R10 sticky"); check_now();
    sec_wr(3'b000);
    expect_item(2, 0, 1, "R7"); expect_item(4, 0, 0, "R10"); check_now();
    sec_wr(3'b010);
    expect_item(2, 0, 3, "R7"); check_now();

    // R5 codes 13, 9 rejected; 14, 4 accepted
    cfg_wr(3, 32'h01838485);
    expect_item(0, 12, 0, "R5"); expect_item(0, 13, 0, "R5");
    expect_item(0, 14, 32'h83, "R5"); expect_item(0, 15, 32'h01, "R5");
    expect_item(4, 0, 1, "R10"); check_now();
    cfg_wr(3, 32'h01838286);
    expect_item(0, 12, 0, "R5"); expect_item(0, 13, 0, "R5"); check_now();

    do_reset();
    expect_item(2, 0, 0, "R11"); expect_item(0, 2, 0, "R11"); check_now();

    sec_wr(3'b100);
    expect_item(2, 0, 4, "R8"); expect_item(4, 0, 0, "R10 bypass only"); check_now();
    cfg_wr(0, 32'h00000080);
    expect_item(0, 0, 32'h80, "R3"); check_now();
    cfg_wr(0, 32'h00000000);
    expect_item(0, 0, 0, "R3 bypass"); expect_item(4, 0, 1, "R10"); check_now();
    cfg_wr(0, 32'h00000080);
    addr_wr(0, 32'h55);
    expect_item(1, 0, 32'h55, "R3 bypass"); check_now();
    sec_wr(3'b000);
    expect_item(2, 0, 0, "R8 clear"); check_now();
    addr_wr(0, 32'h66);
    expect_item(1, 0, 32'h55, "R3"); check_now();
    sec_wr(3'b100);
    expect_item(2, 0, 0, "R8"); check_now();

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule